// File: doc/BRIEF.md
# Dual-Width Mailbox Register File

This block is a small shared store through which an 8-bit microcontroller and a 32-bit host processor exchange data. It holds twelve 16-bit mailbox slots. The microcontroller addresses each slot as two separate bytes at consecutive byte addresses, with the low byte first. The host addresses each slot as one halfword, and consecutive slots sit one 32-bit word apart. A byte written by one side is visible to the other, so the pair of views forms a two-way mailbox. Slot 0 typically carries start-up parameters that the host places there before the microcontroller runs.

Both sides use plain synchronous ports on a common clock. A read returns the addressed data one clock after the address is presented. A write takes effect at the clock edge where it is presented. The host writes through two byte strobes, so it can update either half of a slot alone. If both sides write the same byte in the same cycle, the host write is kept. Only the host-domain reset clears the store. There is no separate microcontroller reset, so the start-up parameters in slot 0 survive any microcontroller restart.

Top module: `mbox_regfile`

## Requirements
- R1: While rstN is low, all 24 bytes and both read outputs are cleared to zero. No other input clears storage, so written values, including slot 0, are held through any number of idle cycles.
- R2: With mcuWe high, mcuWdata is written to byte k when mcuAddr is 0x50+k (k from 0 to 23). mcuRdata shows byte k one clock after mcuAddr = 0x50+k is presented.
- R3: A host read at hostAddr = 0x20+4p (p from 0 to 11) returns byte 2p+1 in bits 15:8 and byte 2p in bits 7:0, one clock later. Bits 31:16 of hostRdata are always zero.
- R4: On a host write to slot p, hostBe bit 0 set stores hostWdata[7:0] into byte 2p, and hostBe bit 1 set stores hostWdata[15:8] into byte 2p+1. A byte whose strobe is clear keeps its value.
- R5: When the host and the microcontroller write the same byte in the same cycle, the host data is stored. A microcontroller write to a different byte in that cycle is still stored.
- R6: A microcontroller address outside 0x50 to 0x67 writes nothing, and a read of it returns zero.
- R7: A host address that is not 0x20+4p with p below 12 (misaligned, below 0x20, or above 0x4C) writes nothing, and a read of it returns zero.
- R8: A read of a location in the same cycle as a write to that location returns the prior content. The new value is returned from the next read on, on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock |
| rstN | input | 1 | Host-domain reset, active low |
| mcuAddr | input | 8 | Microcontroller byte address |
| mcuWe | input | 1 | Microcontroller write enable |
| mcuWdata | input | 8 | Microcontroller write data |
| mcuRdata | output | 8 | Microcontroller read data, one clock after the address |
| hostAddr | input | 12 | Host byte offset within the register group |
| hostWe | input | 1 | Host write enable |
| hostBe | input | 2 | Host byte strobes: bit 0 is the low byte, bit 1 is the high byte |
| hostWdata | input | 16 | Host write data for lanes 15:0 |
| hostRdata | output | 32 | Host read data, bits 31:16 zero |

## Verification
The main function is exercised by byte writes from the microcontroller read back as halfwords by the host, and by halfword writes from the host read back byte by byte. These two patterns separate a swapped byte order from a correct one, and distinguish the 4-byte host stride from the 1-byte microcontroller stride. Single-strobe host writes show whether each strobe reaches only its own byte. Same-byte and different-byte simultaneous writes separate the host-priority rule from a lost or blocked microcontroller write. Addresses just outside each window and misaligned host offsets show that decode rejects neighbours and does not alias them onto valid slots.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int PAIRS = 12;
  localparam int BYTES = 2 * PAIRS;
  localparam int IDXW  = $clog2(BYTES);

  // strobes from the address decoder to the storage
  typedef struct packed {
    logic            mcuWr;
    logic            mcuRdHit;
    logic [IDXW-1:0] mcuIdx;
    logic            hostWrLo;
    logic            hostWrHi;
    logic            hostRdHit;
    logic [IDXW-2:0] hostPair;
  } mboxCtl_t;
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int MCU_AW  = 8,
  parameter int HOST_AW = 12,
  parameter logic [MCU_AW-1:0]  MCU_BASE  = 8'h50,
  parameter logic [HOST_AW-1:0] HOST_BASE = 12'h020
) (
  input  logic [MCU_AW-1:0]  mcuAddr,
  input  logic               mcuWe,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWe,
  input  logic [1:0]         hostBe,
  output mboxCtl_t           ctl
);
  localparam logic [MCU_AW-1:0]  MCU_SPAN  = MCU_AW'(BYTES);
  localparam logic [HOST_AW-3:0] HOST_SPAN = (HOST_AW-2)'(PAIRS);

  logic [MCU_AW-1:0]  mcuRel;
  logic [HOST_AW-1:0] hostRel;
  logic               mcuHit;
  logic               hostHit;
  logic [IDXW-1:0]    mcuIdx;
  logic [IDXW-2:0]    hostPair;
  logic               hostWrLo;
  logic               hostWrHi;
  logic               clash;

  assign mcuRel  = mcuAddr - MCU_BASE;
  assign hostRel = hostAddr - HOST_BASE;

  assign mcuHit  = (mcuAddr >= MCU_BASE) && (mcuRel < MCU_SPAN);
  assign hostHit = (hostAddr >= HOST_BASE) && (hostRel[1:0] == 2'b00) &&
                   (hostRel[HOST_AW-1:2] < HOST_SPAN);

  assign mcuIdx   = mcuRel[IDXW-1:0];
  assign hostPair = hostRel[2 +: (IDXW-1)];

  assign hostWrLo = hostWe && hostHit && hostBe[0];
  assign hostWrHi = hostWe && hostHit && hostBe[1];

  // host side takes the byte when both address it in one cycle
  assign clash = (hostWrLo && (mcuIdx == {hostPair, 1'b0})) ||
                 (hostWrHi && (mcuIdx == {hostPair, 1'b1}));

  always_comb begin
    ctl.mcuWr     = mcuWe && mcuHit && !clash;
    ctl.mcuRdHit  = mcuHit;
    ctl.mcuIdx    = mcuIdx;
    ctl.hostWrLo  = hostWrLo;
    ctl.hostWrHi  = hostWrHi;
    ctl.hostRdHit = hostHit;
    ctl.hostPair  = hostPair;
  end
endmodule

// File: rtl/mbox_store.sv
module mbox_store
  import mbox_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  mboxCtl_t    ctl,
  input  logic [7:0]  mcuWdata,
  input  logic [15:0] hostWdata,
  output logic [7:0]  mcuRdata,
  output logic [31:0] hostRdata
);
  logic [7:0] mem [BYTES];

  for (genvar gi = 0; gi < BYTES; gi++) begin : g_byte
    localparam logic [IDXW-1:0] MY_IDX = IDXW'(gi);
    localparam logic            MY_HI  = MY_IDX[0];
    logic hostHere;
    assign hostHere = (ctl.hostPair == MY_IDX[IDXW-1:1]) &&
                      (MY_HI ? ctl.hostWrHi : ctl.hostWrLo);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mem[gi] <= 8'h00;
      end else if (hostHere) begin
        mem[gi] <= MY_HI ? hostWdata[15:8] : hostWdata[7:0];
      end else if (ctl.mcuWr && (ctl.mcuIdx == MY_IDX)) begin
        mem[gi] <= mcuWdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mcuRdata  <= 8'h00;
      hostRdata <= 32'h0;
    end else begin
      mcuRdata  <= ctl.mcuRdHit ? mem[ctl.mcuIdx] : 8'h00;
      hostRdata <= ctl.hostRdHit ?
                   {16'h0, mem[{ctl.hostPair, 1'b1}], mem[{ctl.hostPair, 1'b0}]} :
                   32'h0;
    end
  end
endmodule

// File: rtl/mbox_regfile.sv
module mbox_regfile
  import mbox_pkg::*;
#(
  parameter int MCU_AW  = 8,
  parameter int HOST_AW = 12,
  parameter logic [MCU_AW-1:0]  MCU_BASE  = 8'h50,
  parameter logic [HOST_AW-1:0] HOST_BASE = 12'h020
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [MCU_AW-1:0]  mcuAddr,
  input  logic               mcuWe,
  input  logic [7:0]         mcuWdata,
  output logic [7:0]         mcuRdata,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWe,
  input  logic [1:0]         hostBe,
  input  logic [15:0]        hostWdata,
  output logic [31:0]        hostRdata
);
  mboxCtl_t ctl;

  mbox_ctrl #(
    .MCU_AW(MCU_AW), .HOST_AW(HOST_AW),
    .MCU_BASE(MCU_BASE), .HOST_BASE(HOST_BASE)
  ) u_ctrl (
    .mcuAddr(mcuAddr), .mcuWe(mcuWe),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostBe(hostBe),
    .ctl(ctl)
  );

  mbox_store u_store (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .mcuWdata(mcuWdata), .hostWdata(hostWdata),
    .mcuRdata(mcuRdata), .hostRdata(hostRdata)
  );
endmodule

// File: rtl/mbox_checker.sv
module mbox_checker
  import mbox_pkg::*;
#(
  parameter int MCU_AW  = 8,
  parameter int HOST_AW = 12,
  parameter logic [MCU_AW-1:0]  MCU_BASE  = 8'h50,
  parameter logic [HOST_AW-1:0] HOST_BASE = 12'h020
) (
  input logic               clk,
  input logic               rstN,
  input logic [MCU_AW-1:0]  mcuAddr,
  input logic               mcuWe,
  input logic [7:0]         mcuWdata,
  input logic [7:0]         mcuRdata,
  input logic [HOST_AW-1:0] hostAddr,
  input logic               hostWe,
  input logic [1:0]         hostBe,
  input logic [15:0]        hostWdata,
  input logic [31:0]        hostRdata,
  input mboxCtl_t           ctl
);
  logic mcuIn;
  logic hostIn;
  assign mcuIn  = (int'(mcuAddr) >= int'(MCU_BASE)) &&
                  (int'(mcuAddr) < int'(MCU_BASE) + BYTES);
  assign hostIn = (int'(hostAddr) >= int'(HOST_BASE)) &&
                  (int'(hostAddr) < int'(HOST_BASE) + 4 * PAIRS) &&
                  (hostAddr[1:0] == 2'b00);

  a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(!rstN) |-> (mcuRdata == 8'h00 && hostRdata == 32'h0));

  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    hostRdata[31:16] == 16'h0);

  a_r6_mcu_outside: assert property (@(posedge clk) disable iff (!rstN)
    !mcuIn |=> mcuRdata == 8'h00);

  a_r7_host_outside: assert property (@(posedge clk) disable iff (!rstN)
    !hostIn |=> hostRdata == 32'h0);

  a_r5_host_priority: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.mcuWr &&
      ((ctl.hostWrLo && ctl.mcuIdx == {ctl.hostPair, 1'b0}) ||
       (ctl.hostWrHi && ctl.mcuIdx == {ctl.hostPair, 1'b1}))));

  a_r2_mcu_roundtrip: assert property (@(posedge clk) disable iff (!rstN)
    (mcuWe && mcuIn && !hostWe) ##1 (mcuAddr == $past(mcuAddr) && !mcuWe && !hostWe)
    |=> mcuRdata == $past(mcuWdata, 2));

  a_r4_low_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (hostWe && hostIn && hostBe == 2'b01 && !mcuWe) ##1
    (hostAddr == $past(hostAddr) && !hostWe && !mcuWe)
    |=> hostRdata[7:0] == $past(hostWdata[7:0], 2));
endmodule

bind mbox_regfile mbox_checker #(
  .MCU_AW(MCU_AW), .HOST_AW(HOST_AW),
  .MCU_BASE(MCU_BASE), .HOST_BASE(HOST_BASE)
) u_chk (
  .clk(clk), .rstN(rstN),
  .mcuAddr(mcuAddr), .mcuWe(mcuWe), .mcuWdata(mcuWdata), .mcuRdata(mcuRdata),
  .hostAddr(hostAddr), .hostWe(hostWe), .hostBe(hostBe),
  .hostWdata(hostWdata), .hostRdata(hostRdata), .ctl(ctl)
);

// File: tb/sim_mbox_regfile.sv
module sim_mbox_regfile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  mcuAddr = 8'h00;
  logic        mcuWe = 1'b0;
  logic [7:0]  mcuWdata = 8'h00;
  logic [7:0]  mcuRdata;
  logic [11:0] hostAddr = 12'h000;
  logic        hostWe = 1'b0;
  logic [1:0]  hostBe = 2'b00;
  logic [15:0] hostWdata = 16'h0;
  logic [31:0] hostRdata;

  int total = 0;
  int bad = 0;
  logic [7:0] model [24];

  always #10 clk = ~clk;

  mbox_regfile u0 (
    .clk(clk), .rstN(rstN),
    .mcuAddr(mcuAddr), .mcuWe(mcuWe), .mcuWdata(mcuWdata), .mcuRdata(mcuRdata),
    .hostAddr(hostAddr), .hostWe(hostWe), .hostBe(hostBe),
    .hostWdata(hostWdata), .hostRdata(hostRdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idleBus();
    mcuWe = 1'b0; hostWe = 1'b0; hostBe = 2'b00;
  endtask

  task automatic mcuWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    idleBus();
    mcuAddr = a; mcuWe = 1'b1; mcuWdata = d;
    @(posedge clk); #1;
    mcuWe = 1'b0;
    if (a >= 8'h50 && a <= 8'h67) model[a - 8'h50] = d;
  endtask

  task automatic mcuRead(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    idleBus();
    mcuAddr = a;
    @(posedge clk); #1;
    v = mcuRdata;
  endtask

  task automatic hostWrite(input logic [11:0] a, input logic [1:0] be,
                           input logic [15:0] d);
    @(negedge clk);
    idleBus();
    hostAddr = a; hostWe = 1'b1; hostBe = be; hostWdata = d;
    @(posedge clk); #1;
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input logic [11:0] a, output logic [31:0] v);
    @(negedge clk);
    idleBus();
    hostAddr = a;
    @(posedge clk); #1;
    v = hostRdata;
  endtask

  function automatic logic [31:0] slotOf(input int p);
    return {16'h0, model[2*p+1], model[2*p]};
  endfunction

  task automatic t_reset();
    logic [7:0] b; logic [31:0] h; bit allOk = 1'b1;
    check(mcuRdata == 8'h00 && hostRdata == 32'h0, "R1 outputs in reset",
          {mcuRdata, hostRdata[23:0]}, 32'h0);
    @(negedge clk); rstN = 1'b1;
    for (int k = 0; k < 24; k++) begin
      mcuRead(8'h50 + 8'(k), b);
      if (b != 8'h00) allOk = 1'b0;
    end
    check(allOk, "R1 bytes zero after reset", {24'h0, b}, 32'h0);
    for (int p = 0; p < 12; p++) begin
      hostRead(12'h020 + 12'(4*p), h);
      check(h == 32'h0, "R1 slot zero after reset", h, 32'h0);
    end
  endtask

  task automatic t_pair_view();
    logic [31:0] h; logic [7:0] b;
    mcuWrite(8'h50, 8'h12);
    mcuWrite(8'h51, 8'h34);
    mcuRead(8'h50, b);
    check(b == 8'h12, "R2 mcu readback low", {24'h0, b}, 32'h12);
    hostRead(12'h020, h);
    check(h == 32'h0000_3412, "R3 slot0 byte order", h, 32'h3412);
    mcuWrite(8'h66, 8'hC3);
    mcuWrite(8'h67, 8'h5E);
    hostRead(12'h04C, h);
    check(h == 32'h0000_5EC3, "R3 last slot stride", h, 32'h5EC3);
    mcuWrite(8'h58, 8'hA1);
    hostRead(12'h030, h);
    check(h == slotOf(4), "R3 slot4 at 0x30", h, slotOf(4));
  endtask

  task automatic t_strobes();
    logic [31:0] h; logic [7:0] b;
    hostWrite(12'h028, 2'b11, 16'hBEEF);
    model[4] = 8'hEF; model[5] = 8'hBE;
    mcuRead(8'h54, b);
    check(b == 8'hEF, "R4 full write low byte", {24'h0, b}, 32'hEF);
    mcuRead(8'h55, b);
    check(b == 8'hBE, "R4 full write high byte", {24'h0, b}, 32'hBE);
    hostWrite(12'h028, 2'b01, 16'h9977);
    model[4] = 8'h77;
    hostRead(12'h028, h);
    check(h == slotOf(2), "R4 low strobe only", h, slotOf(2));
    hostWrite(12'h028, 2'b10, 16'h6611);
    model[5] = 8'h66;
    hostRead(12'h028, h);
    check(h == slotOf(2), "R4 high strobe only", h, slotOf(2));
    hostWrite(12'h028, 2'b00, 16'h0000);
    hostRead(12'h028, h);
    check(h == slotOf(2), "R4 no strobe", h, slotOf(2));
  endtask

  task automatic t_collision();
    logic [7:0] b;
    @(negedge clk);
    mcuAddr = 8'h5A; mcuWe = 1'b1; mcuWdata = 8'h11;
    hostAddr = 12'h034; hostWe = 1'b1; hostBe = 2'b01; hostWdata = 16'h00D4;
    @(posedge clk); #1;
    idleBus();
    model[10] = 8'hD4;
    mcuRead(8'h5A, b);
    check(b == 8'hD4, "R5 host wins same byte", {24'h0, b}, 32'hD4);
    @(negedge clk);
    mcuAddr = 8'h5B; mcuWe = 1'b1; mcuWdata = 8'h2C;
    hostAddr = 12'h038; hostWe = 1'b1; hostBe = 2'b11; hostWdata = 16'h8B7A;
    @(posedge clk); #1;
    idleBus();
    model[11] = 8'h2C; model[12] = 8'h7A; model[13] = 8'h8B;
    mcuRead(8'h5B, b);
    check(b == 8'h2C, "R5 mcu other byte lands", {24'h0, b}, 32'h2C);
    mcuRead(8'h5C, b);
    check(b == 8'h7A, "R5 host other slot lands", {24'h0, b}, 32'h7A);
  endtask

  task automatic t_outside();
    logic [7:0] b; logic [31:0] h; bit same = 1'b1;
    mcuWrite(8'h4F, 8'hFF);
    mcuWrite(8'h68, 8'hFF);
    mcuRead(8'h4F, b);
    check(b == 8'h00, "R6 read below window", {24'h0, b}, 32'h0);
    mcuRead(8'h68, b);
    check(b == 8'h00, "R6 read above window", {24'h0, b}, 32'h0);
    hostWrite(12'h022, 2'b11, 16'hFFFF);
    hostWrite(12'h01C, 2'b11, 16'hFFFF);
    hostWrite(12'h050, 2'b11, 16'hFFFF);
    hostRead(12'h022, h);
    check(h == 32'h0, "R7 misaligned read", h, 32'h0);
    hostRead(12'h050, h);
    check(h == 32'h0, "R7 past last slot read", h, 32'h0);
    hostRead(12'h01C, h);
    check(h == 32'h0, "R7 below first slot read", h, 32'h0);
    for (int p = 0; p < 12; p++) begin
      hostRead(12'h020 + 12'(4*p), h);
      if (h != slotOf(p)) same = 1'b0;
    end
    check(same, "R6 R7 stray writes left store intact", h, slotOf(11));
  endtask

  task automatic t_rdw();
    logic [7:0] b; logic [31:0] h; logic [31:0] old;
    @(negedge clk);
    mcuAddr = 8'h60; mcuWe = 1'b1; mcuWdata = 8'h3D;
    @(posedge clk); #1;
    b = mcuRdata;
    idleBus();
    check(b == model[16], "R8 mcu read during write old", {24'h0, b}, {24'h0, model[16]});
    model[16] = 8'h3D;
    mcuRead(8'h60, b);
    check(b == 8'h3D, "R8 mcu new value next read", {24'h0, b}, 32'h3D);
    old = slotOf(9);
    @(negedge clk);
    hostAddr = 12'h044; hostWe = 1'b1; hostBe = 2'b11; hostWdata = 16'h4E2F;
    @(posedge clk); #1;
    h = hostRdata;
    idleBus();
    check(h == old, "R8 host read during write old", h, old);
    model[18] = 8'h2F; model[19] = 8'h4E;
    hostRead(12'h044, h);
    check(h == 32'h4E2F, "R8 host new value next read", h, 32'h4E2F);
  endtask

  task automatic t_hold();
    logic [31:0] h;
    @(negedge clk); idleBus(); mcuAddr = 8'h00; hostAddr = 12'h000;
    repeat (300) @(posedge clk);
    hostRead(12'h020, h);
    check(h == slotOf(0), "R1 slot0 held while idle", h, slotOf(0));
  endtask

  initial begin
    for (int k = 0; k < 24; k++) model[k] = 8'h00;
    repeat (3) @(posedge clk); #1;
    t_reset();
    t_pair_view();
    t_strobes();
    t_collision();
    t_outside();
    t_rdw();
    t_hold();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule